// File: doc/BRIEF.md
# UART Modem Handshake Controller

This block owns the handshake side of a UART. Two register bits set the Data Terminal Ready and Request To Send output pins. The four active-low handshake inputs (Clear To Send, Data Set Ready, Ring Indicator, Data Carrier Detect) are each brought into the clock domain through a synchroniser. A status register holds the current asserted level of each line and four sticky change flags. The flags raise an interrupt request when the modem interrupt enable is set.

A diagnostic loopback bit turns the block into a self-test path. The transmitter's serial output is fed straight to the receiver's serial input, and the external serial output pin sits at the idle-high level. The DTR control bit stands in for the DSR input and the RTS control bit stands in for the CTS input. Framing and baud generation belong to neighbouring blocks.

The register bus is a simple single-cycle strobe interface. Read data is combinational from the address. A write or a read takes effect at the clock edge where its strobe is high.

Top module: `modem_ctl`

## Requirements
- R1: After reset the control register, the interrupt enable and all four change flags are 0. `pin_dtr_n` and `pin_rts_n` are high, and `irq` is low.
- R2: Control register (address 0): bit 0 is DTR, bit 1 is RTS, bit 4 is loopback, and the other bits read as 0. `pin_dtr_n` is the inverse of bit 0 and `pin_rts_n` is the inverse of bit 1. The register reads back what was written.
- R3: Status register (address 2) bits 4, 5, 6 and 7 hold the complement of the synchronised CTS, DSR, RI and DCD pins, in that order. A pin change shows in the status register two clock edges after it is sampled.
- R4: Status bits 0 (CTS), 1 (DSR) and 3 (DCD) are change flags. Each is set by a falling or a rising edge of its synchronised pin, one edge after the new level reaches the status register.
- R5: Status bit 2 is the ring trailing-edge flag. It is set only when `pin_ri_n` goes from low to high, and never when it goes from high to low.
- R6: A change flag stays set until the status register is read, whatever its line does in the meantime.
- R7: A read of the status register clears all four change flags at that clock edge. An edge that arrives in the same cycle as the read leaves its flag set.
- R8: `irq` is high exactly when bit 0 of the interrupt enable register (address 1) is 1 and at least one change flag is set.
- R9: With loopback set, `core_rxd` follows `core_txd` and `pin_txd` is held high. With loopback clear, `core_rxd` follows `pin_rxd` and `pin_txd` follows `core_txd`.
- R10: With loopback set, status bit 5 (DSR) equals control bit 0 and status bit 4 (CTS) equals control bit 1, whatever the external CTS and DSR pins do.
- R11: Writes to address 2 or 3 change nothing. Address 3 reads as 0 and address 1 reads as the enable in bit 0 with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, which clears the change flags when it reads address 2 |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| pin_cts_n | input | 1 | Clear To Send pin, active low |
| pin_dsr_n | input | 1 | Data Set Ready pin, active low |
| pin_ri_n | input | 1 | Ring Indicator pin, active low |
| pin_dcd_n | input | 1 | Data Carrier Detect pin, active low |
| pin_dtr_n | output | 1 | Data Terminal Ready pin, active low |
| pin_rts_n | output | 1 | Request To Send pin, active low |
| core_txd | input | 1 | Serial output of the transmitter |
| core_rxd | output | 1 | Serial input to the receiver |
| pin_txd | output | 1 | External serial output |
| pin_rxd | input | 1 | External serial input |
| irq | output | 1 | Modem status interrupt request |

## Verification
The hardest case to reach from the ports is the race in R7, where a synchronised edge and a status read land on the same clock edge. The bench changes a pin and counts the synchroniser stages from that change. It raises the read strobe in exactly the cycle where the edge reaches the flag logic, so the read clears an older flag while the new one survives. The ring flag's one-sided behaviour is tested by driving `pin_ri_n` through a full low-high cycle, with a status read between the two halves. This confirms that only the rising half sets the flag.

// File: rtl/modem_pkg.sv
package modem_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 8;
    localparam int N_LINES = 4;

    localparam logic [REG_AW-1:0] ADR_CTL  = 2'd0;
    localparam logic [REG_AW-1:0] ADR_IEN  = 2'd1;
    localparam logic [REG_AW-1:0] ADR_STAT = 2'd2;

    // line order inside the status nibbles
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // control register bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_LOOP = 4;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int WIDTH     = 4,
    parameter int STAGES    = 2,
    parameter logic [WIDTH-1:0] IDLE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= IDLE;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
    parameter int LINES = 4,
    parameter logic [LINES-1:0] RISE_ONLY = 4'b0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    input  logic             clr,
    output logic [LINES-1:0] evt,
    output logic [LINES-1:0] flags
);
    logic [LINES-1:0] prev;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            if (RISE_ONLY[i]) begin : g_rise
                assign evt[i] = lvl[i] & ~prev[i];
            end else begin : g_any
                assign evt[i] = lvl[i] ^ prev[i];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev  <= '1;
            flags <= '0;
        end else begin
            prev  <= lvl;
            flags <= (flags & ~{LINES{clr}}) | evt;
        end
    end
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
    import modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              pin_cts_n,
    input  logic              pin_dsr_n,
    input  logic              pin_ri_n,
    input  logic              pin_dcd_n,
    output logic              pin_dtr_n,
    output logic              pin_rts_n,
    input  logic              core_txd,
    output logic              core_rxd,
    output logic              pin_txd,
    input  logic              pin_rxd,
    output logic              irq
);
    logic               ctl_dtr, ctl_rts, ctl_loop, ien;
    logic [N_LINES-1:0] raw_n, sync_n, evt, flags;
    logic               stat_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_dtr  <= 1'b0;
            ctl_rts  <= 1'b0;
            ctl_loop <= 1'b0;
            ien      <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == ADR_CTL) begin
                ctl_dtr  <= reg_wdata[CB_DTR];
                ctl_rts  <= reg_wdata[CB_RTS];
                ctl_loop <= reg_wdata[CB_LOOP];
            end
            if (reg_addr == ADR_IEN) begin
                ien <= reg_wdata[0];
            end
        end
    end

    assign pin_dtr_n = ~ctl_dtr;
    assign pin_rts_n = ~ctl_rts;

    // loopback: control outputs stand in for the handshake inputs
    always_comb begin
        raw_n[LN_CTS] = ctl_loop ? pin_rts_n : pin_cts_n;
        raw_n[LN_DSR] = ctl_loop ? pin_dtr_n : pin_dsr_n;
        raw_n[LN_RI]  = pin_ri_n;
        raw_n[LN_DCD] = pin_dcd_n;
    end

    assign core_rxd = ctl_loop ? core_txd : pin_rxd;
    assign pin_txd  = ctl_loop ? 1'b1 : core_txd;

    modem_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_n),
        .q    (sync_n)
    );

    assign stat_rd = reg_rd && (reg_addr == ADR_STAT);

    // rising edge of an active-low pin is the trailing edge of ring
    modem_delta #(.LINES(N_LINES), .RISE_ONLY(4'b0100)) u_delta (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sync_n),
        .clr  (stat_rd),
        .evt  (evt),
        .flags(flags)
    );

    always_comb begin
        unique case (reg_addr)
            ADR_CTL:  reg_rdata = {3'b000, ctl_loop, 2'b00, ctl_rts, ctl_dtr};
            ADR_IEN:  reg_rdata = {7'd0, ien};
            ADR_STAT: reg_rdata = {~sync_n, flags};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = ien & (|flags);
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stat_rd,
    input logic       ctl_loop,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [3:0] evt,
    input logic [3:0] flags,
    input logic [3:0] sync_n,
    input logic       core_txd,
    input logic       core_rxd,
    input logic       pin_txd,
    input logic       irq
);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt == 4'd0) |=> flags == 4'd0);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((flags & $past(flags)) == $past(flags)));

    assert_ring_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> ($past(sync_n[2]) == 1'b1));

    assert_txd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_loop |-> pin_txd);

    assert_rxd_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_loop |-> core_rxd == core_txd);

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(stat_rd) || ($past(reg_wr) && $past(reg_addr) == 2'd1)));
endmodule

bind modem_ctl modem_ctl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (stat_rd),
    .ctl_loop(ctl_loop),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .evt     (evt),
    .flags   (flags),
    .sync_n  (sync_n),
    .core_txd(core_txd),
    .core_rxd(core_rxd),
    .pin_txd (pin_txd),
    .irq     (irq)
);

// File: tb/test_modem_ctl.sv
module test_modem_ctl;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       pin_cts_n = 1, pin_dsr_n = 1, pin_ri_n = 1, pin_dcd_n = 1;
    logic       pin_dtr_n, pin_rts_n;
    logic       core_txd = 1, core_rxd, pin_txd, pin_rxd = 1, irq;

    int checks = 0;
    int fails = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    modem_ctl i_modem_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n), .pin_ri_n(pin_ri_n),
        .pin_dcd_n(pin_dcd_n), .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n),
        .core_txd(core_txd), .core_rxd(core_rxd), .pin_txd(pin_txd),
        .pin_rxd(pin_rxd), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    // read at negedge; a status read clears flags at the next posedge
    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rd(2'd0, rv); chk("R1 ctl", rv, 8'h00);
        rd(2'd1, rv); chk("R1 ien", rv, 8'h00);
        rd(2'd2, rv); chk("R1 status", rv, 8'h00);
        chk("R1 pins", {6'd0, pin_dtr_n, pin_rts_n}, 8'h03);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_control();
        wr(2'd0, 8'hFF);
        rd(2'd0, rv); chk("R2 readback", rv, 8'h13);
        wr(2'd0, 8'h01);
        chk("R2 pins dtr", {6'd0, pin_dtr_n, pin_rts_n}, 8'h01);
        wr(2'd0, 8'h02);
        chk("R2 pins rts", {6'd0, pin_dtr_n, pin_rts_n}, 8'h02);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_levels_deltas();
        rd(2'd2, rv);
        @(negedge clk); pin_cts_n = 0;
        @(negedge clk); @(negedge clk);
        #1 chk("R3 cts level timing", reg_rdata, 8'h10);
        @(negedge clk);
        rd(2'd2, rv); chk("R3 R4 cts fall", rv, 8'h11);
        pin_cts_n = 1; pin_dcd_n = 0;
        settle();
        rd(2'd2, rv); chk("R4 cts rise dcd fall", rv, 8'h89);
        pin_dsr_n = 0; settle();
        pin_dsr_n = 1; settle();
        rd(2'd2, rv); chk("R4 R6 dsr sticky", rv, 8'h82);
        pin_dcd_n = 1; settle();
        rd(2'd2, rv);
        rd(2'd2, rv); chk("R7 cleared", rv, 8'h00);
    endtask

    task automatic t_ring();
        pin_ri_n = 0; settle();
        rd(2'd2, rv); chk("R5 ri fall no flag", rv, 8'h40);
        pin_ri_n = 1; settle();
        rd(2'd2, rv); chk("R5 ri rise flag", rv, 8'h04);
        rd(2'd2, rv); chk("R5 cleared", rv, 8'h00);
    endtask

    task automatic t_race();
        pin_dcd_n = 0; settle();          // dcd flag set, older
        @(negedge clk); pin_cts_n = 0;    // sampled at edge k
        @(negedge clk);                   // after edge k
        @(negedge clk);                   // after edge k+1: edge pending
        reg_rd = 1; reg_addr = 2'd2;
        @(negedge clk); reg_rd = 0;       // read and edge meet at k+2
        rd(2'd2, rv); chk("R7 same-cycle edge kept", rv, 8'h91);
        pin_cts_n = 1; pin_dcd_n = 1; settle();
        rd(2'd2, rv);
    endtask

    task automatic t_irq();
        wr(2'd1, 8'hFF);
        rd(2'd1, rv); chk("R11 ien readback", rv, 8'h01);
        chk("R8 irq idle", {7'd0, irq}, 8'h00);
        pin_dsr_n = 0; settle();
        chk("R8 irq set", {7'd0, irq}, 8'h01);
        wr(2'd1, 8'h00);
        chk("R8 irq masked", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h01);
        rd(2'd2, rv);
        chk("R8 irq after read", {7'd0, irq}, 8'h00);
        pin_dsr_n = 1; settle(); rd(2'd2, rv);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_loop();
        core_txd = 0; pin_rxd = 1; #1;
        chk("R9 normal rxd", {7'd0, core_rxd}, 8'h01);
        chk("R9 normal txd", {7'd0, pin_txd}, 8'h00);
        pin_cts_n = 0;                    // external asserted CTS, DSR idle
        wr(2'd0, 8'h11);                  // loop, dtr=1, rts=0
        settle(); rd(2'd2, rv);
        #1;
        chk("R9 loop rxd", {7'd0, core_rxd}, 8'h00);
        chk("R9 loop txd", {7'd0, pin_txd}, 8'h01);
        rd(2'd2, rv); chk("R10 dsr from dtr", rv, 8'h20);
        wr(2'd0, 8'h12); settle();
        rd(2'd2, rv); chk("R10 cts from rts", rv, 8'h13);
        wr(2'd0, 8'h00); pin_cts_n = 1; core_txd = 1; settle();
        rd(2'd2, rv);
    endtask

    task automatic t_ignored();
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        rd(2'd3, rv); chk("R11 addr3 zero", rv, 8'h00);
        rd(2'd2, rv); chk("R11 status unaffected", rv, 8'h00);
        rd(2'd0, rv); chk("R11 ctl unaffected", rv, 8'h00);
        rd(2'd1, rv); chk("R11 ien unaffected", rv, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_control();
        t_levels_deltas();
        t_ring();
        t_race();
        t_irq();
        t_loop();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule